// File: doc/BRIEF.md
# Strap-Entered XOR Chain Test Block

This block provides the on-die logic for board-level connectivity testing. When power-good rises, it captures a set of configuration straps once and decides whether the die enters XOR test mode. In test mode, every group of input pads folds into a parity chain. Each chain's result drives its own output pad, which replaces the normal strap or reserved function of that pad. Automated board testers first drive every chain input to 1 and check the known result. They then walk a single 0 along the inputs. The output must toggle on each step, and a missing toggle points to a broken pad, ball or trace.

There are `NUM_GRP` plain chains, each `GRP_W` pads wide. One extra chain, the last one, covers the receive and transmit differential lanes. Its membership depends on two more latched straps: a width strap and a lane-reversal strap. This lets boards that route only half of the lanes still test the half they have. Lanes left out of that chain are forced to 0, so they do not change its parity.

Top module: `xor_chain_tester`

## Requirements
- R1: At the first rising clock edge with `pwr_good` high, the block latches the straps. Test mode is entered exactly when `strap_bsel[0]` is 1 and `strap_xtest` is 0. `test_mode` reflects the decision from that edge on.
- R2: The values of `strap_bsel[2:1]` have no effect on the mode decision or on any output.
- R3: While `pwr_good` stays high, later strap changes do not alter the mode or the chain membership.
- R4: When `pwr_good` is low, `test_mode`, `chain_out` and `chain_oe` are all 0, and the latch is re-armed for the next rise.
- R5: In test mode, the output of plain chain g (bit g of `chain_out`, g < NUM_GRP) is the inverted XOR of pads `grp_pads[g*GRP_W +: GRP_W]`. With all of its inputs at 1, it reads 1 for an even count and 0 for an odd count.
- R6: In test mode, driving any single input of a chain to 0 while the rest stay at 1 inverts that chain's output compared with the all-ones value.
- R7: Lane chain membership, when the latched `strap_wide` is 1: all `LANES` lanes of `rx_p`, `rx_n`, `tx_p` and `tx_n` are members, whatever `strap_rev` is.
- R8: Lane chain membership, when `strap_wide` is 0 and `strap_rev` is 0: only lanes LANES-1 down to LANES/2 are members.
- R9: Lane chain membership, when `strap_wide` is 0 and `strap_rev` is 1: only lanes LANES/2-1 down to 0 are members.
- R10: Output in test mode: the lane chain (bit NUM_GRP of `chain_out`) is the inverted XOR of its member lanes. Non-member lanes have no effect on it.
- R11: Outside test mode, `chain_out` and `chain_oe` are all 0. In test mode, every bit of `chain_oe` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock used to sample power-good |
| pwr_good | input | 1 | Power-good; low clears the block asynchronously |
| strap_bsel | input | 3 | Bus-select straps; bit 0 must be 1 for test mode |
| strap_xtest | input | 1 | Test strap; must be 0 for test mode |
| strap_wide | input | 1 | Lane chain covers all lanes when 1 |
| strap_rev | input | 1 | Picks the lower lane half when the width strap is 0 |
| grp_pads | input | NUM_GRP*GRP_W | Pads of the plain chains, GRP_W per chain |
| rx_p | input | LANES | Receive lanes, positive leg |
| rx_n | input | LANES | Receive lanes, negative leg |
| tx_p | input | LANES | Transmit lanes, positive leg |
| tx_n | input | LANES | Transmit lanes, negative leg |
| test_mode | output | 1 | Latched test-mode decision |
| chain_out | output | NUM_GRP+1 | Chain results; the top bit is the lane chain |
| chain_oe | output | NUM_GRP+1 | Output enable for each shared pad |

## Verification
The bench builds the block with 14 plain chains of 5 pads and 8 lanes. An odd chain width makes the all-ones result of the plain chains 0. The lane chain always has an even count (32 members when full width, 16 when half width), so it reads 1. Both seed outcomes are therefore checked in one build. The small lane count keeps the half-lane boundary at lane 4, which lets the walking and masking checks reach both sides of it in a few cycles.

// File: rtl/xor_chain_tester.sv
module xor_chain_tester #(
  parameter int NUM_GRP = 14,
  parameter int GRP_W   = 8,
  parameter int LANES   = 16
) (
  input  logic                     clk,
  input  logic                     pwr_good,
  input  logic [2:0]               strap_bsel,
  input  logic                     strap_xtest,
  input  logic                     strap_wide,
  input  logic                     strap_rev,
  input  logic [NUM_GRP*GRP_W-1:0] grp_pads,
  input  logic [LANES-1:0]         rx_p,
  input  logic [LANES-1:0]         rx_n,
  input  logic [LANES-1:0]         tx_p,
  input  logic [LANES-1:0]         tx_n,
  output logic                     test_mode,
  output logic [NUM_GRP:0]         chain_out,
  output logic [NUM_GRP:0]         chain_oe
);
  localparam int NCH  = NUM_GRP + 1;
  localparam int HALF = LANES / 2;

  logic armed_q, mode_q, wide_q, rev_q;
  logic [LANES-1:0] lane_en, lane_bits;
  logic [NCH-1:0]   raw;
  logic             unused_bsel;

  assign unused_bsel = ^strap_bsel[2:1];

  always_ff @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      armed_q <= 1'b0;
      mode_q  <= 1'b0;
      wide_q  <= 1'b0;
      rev_q   <= 1'b0;
    end else if (!armed_q) begin
      armed_q <= 1'b1;
      mode_q  <= strap_bsel[0] & ~strap_xtest;
      wide_q  <= strap_wide;
      rev_q   <= strap_rev;
    end
  end

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    if (l < HALF) begin : g_lo
      assign lane_en[l] = wide_q | rev_q;
    end else begin : g_hi
      assign lane_en[l] = wide_q | ~rev_q;
    end
  end

  assign lane_bits = (rx_p ^ rx_n ^ tx_p ^ tx_n) & lane_en;

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_chain
    assign raw[g] = ~^grp_pads[g*GRP_W +: GRP_W];
  end
  assign raw[NUM_GRP] = ~^lane_bits;

  assign test_mode = mode_q;
  assign chain_out = mode_q ? raw : '0;
  assign chain_oe  = {NCH{mode_q}};
endmodule

module xor_chain_tester_chk #(
  parameter int NUM_GRP = 14,
  parameter int GRP_W   = 8
) (
  input logic             clk,
  input logic             pwr_good,
  input logic             bsel0,
  input logic             strap_xtest,
  input logic [GRP_W-1:0] pads0,
  input logic             armed_q,
  input logic             test_mode,
  input logic [NUM_GRP:0] chain_out,
  input logic [NUM_GRP:0] chain_oe
);
  localparam logic EVEN_SEED = (GRP_W % 2 == 0);

  a_r1_entry: assert property (@(posedge clk) disable iff (!pwr_good)
    $rose(armed_q) |-> test_mode == ($past(bsel0) && !$past(strap_xtest)));

  a_r3_hold: assert property (@(posedge clk) disable iff (!pwr_good)
    armed_q |=> $stable(test_mode));

  a_r11_idle: assert property (@(posedge clk) disable iff (!pwr_good)
    !test_mode |-> (chain_out == '0 && chain_oe == '0));

  a_r11_drive: assert property (@(posedge clk) disable iff (!pwr_good)
    test_mode |-> &chain_oe);

  a_r5_seed: assert property (@(posedge clk) disable iff (!pwr_good)
    (test_mode && &pads0) |-> chain_out[0] == EVEN_SEED);
endmodule

bind xor_chain_tester xor_chain_tester_chk #(.NUM_GRP(NUM_GRP), .GRP_W(GRP_W)) chk_i (
  .clk(clk), .pwr_good(pwr_good), .bsel0(strap_bsel[0]), .strap_xtest(strap_xtest),
  .pads0(grp_pads[GRP_W-1:0]), .armed_q(armed_q), .test_mode(test_mode),
  .chain_out(chain_out), .chain_oe(chain_oe));

// File: tb/xor_chain_tester_tb.sv
module xor_chain_tester_tb_top;
  localparam int NG = 14;
  localparam int GW = 5;
  localparam int LN = 8;

  logic clk = 0;
  logic pwr_good = 0;
  logic [2:0] strap_bsel = 3'b001;
  logic strap_xtest = 0, strap_wide = 1, strap_rev = 0;
  logic [NG*GW-1:0] grp_pads = '1;
  logic [LN-1:0] rx_p = '1, rx_n = '1, tx_p = '1, tx_n = '1;
  logic test_mode;
  logic [NG:0] chain_out, chain_oe;

  int errors = 0, checks = 0;
  bit run = 0;
  string cur_req = "R4";

  always #5 clk = ~clk;

  xor_chain_tester #(.NUM_GRP(NG), .GRP_W(GW), .LANES(LN)) dut_i (
    .clk(clk), .pwr_good(pwr_good), .strap_bsel(strap_bsel), .strap_xtest(strap_xtest),
    .strap_wide(strap_wide), .strap_rev(strap_rev), .grp_pads(grp_pads),
    .rx_p(rx_p), .rx_n(rx_n), .tx_p(tx_p), .tx_n(tx_n),
    .test_mode(test_mode), .chain_out(chain_out), .chain_oe(chain_oe));

  bit m_armed = 0, m_mode = 0, m_wide = 0, m_rev = 0;
  always @(posedge clk or negedge pwr_good) begin
    if (!pwr_good) begin
      m_armed <= 0; m_mode <= 0; m_wide <= 0; m_rev <= 0;
    end else if (!m_armed) begin
      m_armed <= 1;
      m_mode  <= (strap_bsel[0] == 1'b1) && (strap_xtest == 1'b0);
      m_wide  <= strap_wide;
      m_rev   <= strap_rev;
    end
  end

  function automatic logic [NG:0] model_out();
    logic [NG:0] r;
    r = '0;
    if (!m_mode) return r;
    for (int g = 0; g < NG; g++) begin
      int ones = 0;
      for (int i = 0; i < GW; i++) ones += grp_pads[g*GW+i];
      r[g] = (ones % 2 == 0);
    end
    begin
      int ones = 0;
      for (int l = 0; l < LN; l++) begin
        bit member = m_wide || (m_rev ? (l < LN/2) : (l >= LN/2));
        if (member) ones += rx_p[l] + rx_n[l] + tx_p[l] + tx_n[l];
      end
      r[NG] = (ones % 2 == 0);
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) if (run) begin
    logic [NG:0] e;
    e = model_out();
    check(chain_out === e, {cur_req, " model chain_out"}, 32'(chain_out), 32'(e));
    check(chain_oe === {(NG+1){m_mode}}, {cur_req, " model chain_oe"}, 32'(chain_oe), 32'({(NG+1){m_mode}}));
    check(test_mode === m_mode, {cur_req, " model test_mode"}, 32'(test_mode), 32'(m_mode));
  end

  task automatic step();
    @(posedge clk); #2;
  endtask

  task automatic settle();
    @(negedge clk); #1;
  endtask

  task automatic power_up(input logic [2:0] b, input logic x, input logic w, input logic r);
    step();
    pwr_good = 0;
    strap_bsel = b; strap_xtest = x; strap_wide = w; strap_rev = r;
    step(); step();
    pwr_good = 1;
    step();
  endtask

  task automatic all_ones();
    grp_pads = '1; rx_p = '1; rx_n = '1; tx_p = '1; tx_n = '1;
  endtask

  initial begin
    #(200000 * 10);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic base;
    settle();
    cur_req = "R4";
    check(test_mode === 0 && chain_out === '0 && chain_oe === '0, "R4 reset state",
          32'(chain_out), 0);
    run = 1;

    // R1 entry with valid straps, R5 odd seed, R7 full lanes, R11 drive
    cur_req = "R1"; power_up(3'b001, 0, 1, 0); all_ones(); settle();
    check(test_mode === 1, "R1 entry", 32'(test_mode), 1);
    cur_req = "R5";
    check(chain_out[NG-1:0] === '0, "R5 odd all-ones gives 0", 32'(chain_out[NG-1:0]), 0);
    cur_req = "R7";
    check(chain_out[NG] === 1, "R7 full lanes even count", 32'(chain_out[NG]), 1);
    check(&chain_oe, "R11 oe in mode", 32'(chain_oe), 32'({(NG+1){1'b1}}));

    // R6 walking zero on chain 3 and across lanes
    cur_req = "R6"; base = chain_out[3];
    for (int i = 0; i < GW; i++) begin
      step(); grp_pads = '1; grp_pads[3*GW+i] = 0; settle();
      check(chain_out[3] === ~base, "R6 walking zero plain chain", 32'(chain_out[3]), 32'(~base));
    end
    step(); all_ones();
    for (int l = 0; l < LN; l++) begin
      step(); all_ones(); tx_n[l] = 0; settle();
      check(chain_out[NG] === 0, "R6 R7 walking zero lane chain", 32'(chain_out[NG]), 0);
    end

    // R3 straps change after latch
    cur_req = "R3"; step(); all_ones();
    strap_xtest = 1; strap_bsel = 3'b110; strap_wide = 0; strap_rev = 1;
    step(); step(); rx_p[LN-1] = 0; settle();
    check(test_mode === 1, "R3 mode held", 32'(test_mode), 1);
    check(chain_out[NG] === 0, "R3 membership held", 32'(chain_out[NG]), 0);

    // R4 power-good low
    cur_req = "R4"; step(); pwr_good = 0; settle();
    check(test_mode === 0 && chain_oe === '0 && chain_out === '0, "R4 pwr low clears",
          32'(chain_oe), 0);

    // R1 refusals, R11 idle outputs
    cur_req = "R1"; power_up(3'b110, 0, 1, 0); all_ones(); grp_pads[0] = 0; settle();
    check(test_mode === 0, "R1 bsel0=0 refused", 32'(test_mode), 0);
    check(chain_out === '0 && chain_oe === '0, "R11 idle outputs low", 32'(chain_out), 0);
    power_up(3'b001, 1, 1, 0); settle();
    check(test_mode === 0, "R1 xtest=1 refused", 32'(test_mode), 0);

    // R2 upper bus-select bits ignored
    cur_req = "R2";
    for (int b = 0; b < 4; b++) begin
      power_up({b[1:0], 1'b1}, 0, 1, 0); all_ones(); settle();
      check(test_mode === 1 && chain_out[0] === 0, "R2 bsel[2:1] ignored", 32'(test_mode), 1);
    end

    // R8 upper half only
    cur_req = "R8"; power_up(3'b001, 0, 0, 0); all_ones(); settle();
    check(chain_out[NG] === 1, "R8 half all-ones", 32'(chain_out[NG]), 1);
    step(); rx_n[0] = 0; settle();
    check(chain_out[NG] === 1, "R8 R10 lower lane excluded", 32'(chain_out[NG]), 1);
    step(); rx_n[0] = 1; rx_n[LN/2] = 0; settle();
    check(chain_out[NG] === 0, "R8 lane LN/2 included", 32'(chain_out[NG]), 0);

    // R9 lower half only
    cur_req = "R9"; power_up(3'b001, 0, 0, 1); all_ones(); tx_p[LN-1] = 0; settle();
    check(chain_out[NG] === 1, "R9 R10 upper lane excluded", 32'(chain_out[NG]), 1);
    step(); tx_p[LN-1] = 1; tx_p[LN/2-1] = 0; settle();
    check(chain_out[NG] === 0, "R9 lane LN/2-1 included", 32'(chain_out[NG]), 0);

    // R10 mixed patterns against the model, each half mode
    cur_req = "R10";
    for (int m = 0; m < 3; m++) begin
      power_up(3'b001, 0, m == 2, m == 1);
      for (int k = 0; k < 40; k++) begin
        step();
        grp_pads = {3{$urandom()}};
        rx_p = LN'($urandom()); rx_n = LN'($urandom());
        tx_p = LN'($urandom()); tx_n = LN'($urandom());
      end
    end

    step(); run = 0;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule